// File: doc/BRIEF.md
# Digital throttle frame transmitter

This block turns a motor throttle command into a single-wire pulse train for a speed controller. A host offers an 11-bit throttle value and a telemetry-request flag on a valid/ready handshake. When the block accepts them it adds a 4-bit checksum to make a 16-bit word. It then sends that word one bit per fixed period on one output line. Every bit starts with the line high. The length of the high time tells a 0 from a 1, and the line stays low for the rest of the period.

One of four bit rates is chosen with a 2-bit mode input: 150, 300, 600 or 1200 kbit/s. A configuration input sets how many bit periods of low line must follow each frame before the next one is taken. All cycle counts are derived from a clock-frequency parameter and rounded to the nearest clock cycle.

Top module: `esc_frame_tx`

## Requirements
- R1: Each bit lasts exactly P clock cycles, where P = round(CLK_HZ / rate) and rate = 150,000 × 2^mode bit/s. Mode 0 gives 150k, 1 gives 300k, 2 gives 600k and 3 gives 1200k. At 50 MHz, P is 333, 167, 83 and 42.
- R2: A 0 bit drives the line high for the first round(3·CLK_HZ / (8·rate)) cycles of its period and low for the rest. At 50 MHz this is 125, 63, 31 and 16 cycles.
- R3: A 1 bit drives the line high for the first round(3·CLK_HZ / (4·rate)) cycles of its period and low for the rest. At 50 MHz this is 250, 125, 63 and 31 cycles.
- R4: The 16 bits go out most significant first: throttle bits 10 down to 0, then the telemetry flag, then checksum bits 3 down to 0.
- R5: The checksum is the XOR of the three 4-bit nibbles of the 12-bit value {throttle, telemetry}.
- R6: A frame is accepted on a clock edge where s_valid and s_ready are both high. The line goes high in the first cycle after that edge.
- R7: After the last bit the line stays low for G·P cycles, where G is the idle setting and values below 2 count as 2. s_ready returns high in the cycle that follows.
- R8: From acceptance until the idle gap has ended, s_ready is low and busy_o is high. s_valid during that time starts nothing.
- R9: The mode, the payload and the idle setting are captured at acceptance. Changes to them while a frame is in flight do not alter that frame or its gap.
- R10: Under reset the line is low, s_ready is high and busy_o is low. While not busy the line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Bit-rate select, 0..3 for 150/300/600/1200 kbit/s |
| idle_bits_i | input | IDLE_W (6) | Idle gap after a frame, in bit periods (minimum 2) |
| s_valid | input | 1 | Command offered |
| s_ready | output | 1 | Block can take a command |
| throttle_i | input | 11 | Throttle value |
| telem_i | input | 1 | Telemetry-request flag |
| line_o | output | 1 | Serial pulse output |
| busy_o | output | 1 | Frame or idle gap in progress |

## Verification
The checker assumes that s_valid can only cause a frame while s_ready is high. It also assumes that the inputs settle before each edge, so that a rising busy_o always follows a cycle with s_valid high. The bench drives every input on the falling edge and waits for s_ready before it counts on acceptance. The checker bounds each high pulse by the longest 1-bit high time. That bound holds only if the mode stays one of the four legal codes. The stimulus uses nothing else, and it exercises mid-frame input changes only through the normal port interface.

// File: rtl/esc_tx_pkg.sv
package esc_tx_pkg;

    localparam int FRAME_BITS = 16;
    localparam int THR_W      = 11;
    localparam int SUM_W      = 4;
    localparam int NUM_RATES  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BITS = 2'd1,
        ST_GAP  = 2'd2
    } tx_state_e;

    // integer division rounded to nearest, halves up
    function automatic longint unsigned round_div(longint unsigned num, longint unsigned den);
        return (2 * num + den) / (2 * den);
    endfunction

endpackage

// File: rtl/esc_tx_timing.sv
module esc_tx_timing
    import esc_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned BASE_RATE = 150_000,
    parameter int unsigned CNT_W     = 9
) (
    input  logic [1:0]       mode,
    output logic [CNT_W-1:0] period_cyc,
    output logic [CNT_W-1:0] t0h_cyc,
    output logic [CNT_W-1:0] t1h_cyc
);

    logic [CNT_W-1:0] per_tab [NUM_RATES];
    logic [CNT_W-1:0] lo_tab  [NUM_RATES];
    logic [CNT_W-1:0] hi_tab  [NUM_RATES];

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_rate
        localparam longint unsigned RATE = longint'(BASE_RATE) * (64'd1 << i);
        localparam longint unsigned PER  = round_div(longint'(CLK_HZ), RATE);
        localparam longint unsigned LO   = round_div(longint'(CLK_HZ) * 3, RATE * 8);
        localparam longint unsigned HI   = round_div(longint'(CLK_HZ) * 3, RATE * 4);
        assign per_tab[i] = CNT_W'(PER);
        assign lo_tab[i]  = CNT_W'(LO);
        assign hi_tab[i]  = CNT_W'(HI);
    end

    assign period_cyc = per_tab[mode];
    assign t0h_cyc    = lo_tab[mode];
    assign t1h_cyc    = hi_tab[mode];

endmodule

// File: rtl/esc_tx_sum.sv
module esc_tx_sum #(
    parameter int DATA_W = 12,
    parameter int SUM_W  = 4
) (
    input  logic [DATA_W-1:0] data,
    output logic [SUM_W-1:0]  sum
);

    localparam int NIBS = DATA_W / SUM_W;

    logic [SUM_W-1:0] part [NIBS+1];

    assign part[0] = '0;
    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        assign part[n+1] = part[n] ^ data[n*SUM_W +: SUM_W];
    end

    assign sum = part[NIBS];

endmodule

// File: rtl/esc_frame_tx.sv
module esc_frame_tx
    import esc_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned BASE_RATE = 150_000,
    parameter int unsigned IDLE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [IDLE_W-1:0] idle_bits_i,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [THR_W-1:0]  throttle_i,
    input  logic              telem_i,
    output logic              line_o,
    output logic              busy_o
);

    localparam int unsigned MAX_PER = int'(round_div(longint'(CLK_HZ), longint'(BASE_RATE)));
    localparam int unsigned CNT_W   = $clog2(MAX_PER + 1);
    localparam int unsigned IDX_W   = $clog2(FRAME_BITS);
    localparam int unsigned PAY_W   = THR_W + 1;

    typedef struct packed {
        tx_state_e              st;
        logic [FRAME_BITS-1:0]  shreg;
        logic [1:0]             mode;
        logic [IDLE_W-1:0]      gap;
        logic [IDX_W-1:0]       bit_idx;
        logic [CNT_W-1:0]       cyc;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    logic [CNT_W-1:0] period_cyc, t0h_cyc, t1h_cyc;
    logic [SUM_W-1:0] sum;
    logic             period_end;

    esc_tx_timing #(
        .CLK_HZ    (CLK_HZ),
        .BASE_RATE (BASE_RATE),
        .CNT_W     (CNT_W)
    ) u_timing (
        .mode       (r_q.mode),
        .period_cyc (period_cyc),
        .t0h_cyc    (t0h_cyc),
        .t1h_cyc    (t1h_cyc)
    );

    esc_tx_sum #(
        .DATA_W (PAY_W),
        .SUM_W  (SUM_W)
    ) u_sum (
        .data ({throttle_i, telem_i}),
        .sum  (sum)
    );

    assign period_end = (r_q.cyc == period_cyc - CNT_W'(1));

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (s_valid) begin
                    r_d.st      = ST_BITS;
                    r_d.shreg   = {throttle_i, telem_i, sum};
                    r_d.mode    = mode_i;
                    r_d.gap     = (idle_bits_i < IDLE_W'(2)) ? IDLE_W'(2) : idle_bits_i;
                    r_d.bit_idx = IDX_W'(FRAME_BITS - 1);
                    r_d.cyc     = '0;
                end
            end
            ST_BITS: begin
                if (period_end) begin
                    r_d.cyc   = '0;
                    r_d.shreg = {r_q.shreg[FRAME_BITS-2:0], 1'b0};
                    if (r_q.bit_idx == '0) begin
                        r_d.st = ST_GAP;
                    end else begin
                        r_d.bit_idx = r_q.bit_idx - IDX_W'(1);
                    end
                end else begin
                    r_d.cyc = r_q.cyc + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (period_end) begin
                    r_d.cyc = '0;
                    if (r_q.gap == IDLE_W'(1)) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.gap = r_q.gap - IDLE_W'(1);
                    end
                end else begin
                    r_d.cyc = r_q.cyc + CNT_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign s_ready = (r_q.st == ST_IDLE);
    assign busy_o  = (r_q.st != ST_IDLE);
    assign line_o  = (r_q.st == ST_BITS) &&
                     (r_q.cyc < (r_q.shreg[FRAME_BITS-1] ? t1h_cyc : t0h_cyc));

endmodule

// File: rtl/esc_frame_tx_checker.sv
module esc_frame_tx_checker
    import esc_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned BASE_RATE = 150_000
) (
    input logic clk,
    input logic rst_n,
    input logic s_valid,
    input logic s_ready,
    input logic line_o,
    input logic busy_o
);

    localparam int unsigned HI_MAX = int'(round_div(longint'(CLK_HZ) * 3, longint'(BASE_RATE) * 4));

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n)      hi_run <= '0;
        else if (line_o) hi_run <= hi_run + 16'd1;
        else             hi_run <= '0;
    end

    AST_HIGH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= 16'(HI_MAX)); // R3

    AST_LINE_LOW_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_o); // R10

    AST_ACCEPT_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (busy_o && line_o)); // R6

    AST_BUSY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(s_valid)); // R8

    AST_GAP_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(!line_o)); // R7

    AST_PULSE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_o) |-> !s_ready); // R1

endmodule

bind esc_frame_tx esc_frame_tx_checker #(
    .CLK_HZ    (CLK_HZ),
    .BASE_RATE (BASE_RATE)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .line_o  (line_o),
    .busy_o  (busy_o)
);

// File: tb/esc_frame_tx_bench.sv
module esc_frame_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [5:0]  idle_bits_i = 6'd21;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [10:0] throttle_i = '0;
    logic        telem_i = 1'b0;
    logic        line_o;
    logic        busy_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    esc_frame_tx u_esc_frame_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .idle_bits_i (idle_bits_i),
        .s_valid     (s_valid),
        .s_ready     (s_ready),
        .throttle_i  (throttle_i),
        .telem_i     (telem_i),
        .line_o      (line_o),
        .busy_o      (busy_o)
    );

    // {mode[1:0], throttle[10:0], telemetry, idle[5:0]}
    localparam logic [19:0] VECS [6] = '{
        {2'd3, 11'h7FF,  1'b1, 6'd21},
        {2'd2, 11'h000,  1'b0, 6'd21},
        {2'd1, 11'h555,  1'b0, 6'd4},
        {2'd0, 11'h2AB,  1'b1, 6'd2},
        {2'd3, 11'd48,   1'b1, 6'd0},
        {2'd2, 11'd1047, 1'b0, 6'd1}
    };

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [1:0] m, input logic [10:0] thr, input logic tel,
                             input logic [5:0] gcfg, input bit perturb);
        real         rate;
        int          p, h0, h1, g, hc, shape_err, gap_err;
        logic [11:0] pay;
        logic [3:0]  ck;
        logic [15:0] exp_w, got;
        logic        first_hi;
        rate  = 150000.0 * real'(1 << m);
        p     = $rtoi(50.0e6 / rate + 0.5);
        h0    = $rtoi(50.0e6 * 3.0 / (8.0 * rate) + 0.5);
        h1    = $rtoi(50.0e6 * 3.0 / (4.0 * rate) + 0.5);
        g     = (gcfg < 2) ? 2 : int'(gcfg);
        pay   = {thr, tel};
        ck    = pay[11:8] ^ pay[7:4] ^ pay[3:0];
        exp_w = {thr, tel, ck};
        got   = '0;
        shape_err = 0;
        gap_err   = 0;
        first_hi  = 1'b0;

        @(negedge clk);
        mode_i = m; throttle_i = thr; telem_i = tel; idle_bits_i = gcfg; s_valid = 1'b1;
        while (!s_ready) @(negedge clk);

        for (int b = 15; b >= 0; b--) begin
            hc = 0;
            for (int c = 0; c < p; c++) begin
                @(negedge clk);
                if (b == 15 && c == 0) begin
                    first_hi = line_o;
                    if (perturb) begin
                        mode_i = ~m; throttle_i = ~thr; telem_i = ~tel; idle_bits_i = 6'd40;
                    end else begin
                        s_valid = 1'b0;
                    end
                end
                if (line_o) hc++;
                if (line_o !== (c < (exp_w[b] ? h1 : h0))) shape_err++;
                if (s_ready || !busy_o) shape_err++;
            end
            got[b] = (hc > (h0 + h1) / 2);
        end

        for (int k = 0; k < g * p; k++) begin
            @(negedge clk);
            if (line_o || s_ready || !busy_o) gap_err++;
        end
        @(negedge clk);
        check(s_ready && !busy_o, perturb ? "R9 ready after gap" : "R7 ready after gap",
              {s_ready, busy_o}, 2'b10);
        s_valid = 1'b0;

        check(first_hi, "R6 line high after accept", first_hi, 1);
        if (perturb) begin
            check(got == exp_w, "R9 frame word", got, exp_w);
            check(shape_err == 0, "R9 pulse shape", shape_err, 0);
            check(gap_err == 0, "R9 gap", gap_err, 0);
        end else begin
            check(got == exp_w, "R4 R5 frame word", got, exp_w);
            check(shape_err == 0, "R1 R2 R3 R8 pulse shape", shape_err, 0);
            check(gap_err == 0, "R7 R8 gap low", gap_err, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!line_o && s_ready && !busy_o, "R10 state in reset", {line_o, s_ready, busy_o}, 3'b010);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!line_o && s_ready && !busy_o, "R10 state after reset", {line_o, s_ready, busy_o}, 3'b010);

        for (int i = 0; i < 6; i++) begin
            run_frame(VECS[i][19:18], VECS[i][17:7], VECS[i][6], VECS[i][5:0], 1'b0);
        end

        // R9: inputs changed right after acceptance, valid held high during the frame
        run_frame(2'd3, 11'h3C5, 1'b0, 6'd3, 1'b1);
        run_frame(2'd2, 11'h001, 1'b1, 6'd2, 1'b1);

        // R10: line stays low while idle with no valid
        repeat (20) @(negedge clk);
        check(!line_o && !busy_o, "R10 idle line low", {line_o, busy_o}, 2'b00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule